// File: doc/BRIEF.md
# DMA Error Status Capture

This block records memory errors that surface while a bus master performs DMA. It holds two 64-bit status registers: one for uncorrectable errors and one for correctable errors. Both registers share a single fault address register. The first error seen by a status register becomes its primary record. That record keeps the direction, the byte mask, the doubleword offset and the block flag. The correctable register also keeps the ECC syndrome, and the uncorrectable register also keeps a translation-failure flag. Errors that arrive while a primary record is held only set a secondary bit for their direction, so software can tell that more errors happened.

Software reads the three registers through a small read/write port. It clears status bits by writing ones to them. Each status register drives its own interrupt line. The line stays high while any of that register's primary or secondary event bits is set. Error reports come in on two event ports, one for each severity, and each report carries its fields in the same cycle as its strobe.

Top module: `dma_err_capture`

## Requirements
- R1: While reset is active, both status registers and the fault address register are cleared to zero, and both interrupt lines are low.
- R2: An uncorrectable event that arrives when no primary bit is held sets bit 62 for a read or bit 61 for a write. If it is a translation failure, it also sets bit 56. It loads the byte mask into bits 47:32, event address bits 5:3 into bits 31:29, and the block flag into bit 23.
- R3: A correctable event that arrives when no primary bit is held captures the same direction, mask, offset and block fields as in R2, and also loads its 8-bit syndrome into bits 55:48. Bits 57:56 of the correctable register always read zero, and bits 55:48 of the uncorrectable register always read zero.
- R4: An event that arrives while a primary bit (62, 61 or 56) is held sets only a secondary bit: bit 59 for a read or bit 58 for a write. In the uncorrectable register, a translation failure also sets bit 57. The mask, offset, block and syndrome fields stay unchanged.
- R5: A write to register select 0 (uncorrectable) or 1 (correctable) clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R6: Each interrupt line is high exactly when one of bits 62, 61, 59, 58, 57 or 56 of its register is set. The mask, offset, block and syndrome fields alone do not raise it.
- R7: The fault address register loads the full event address when a register captures a primary record while the other register holds no primary bit. If both capture in the same cycle, the uncorrectable address wins. While either register holds a primary bit, the fault address register does not change.
- R8: A clearing write and an event to the same register in the same cycle apply the clear first. If the clear removes the held primary bits, the event is captured as a new primary record.
- R9: Reads return the uncorrectable status for select 0, the correctable status for select 1, and the zero-extended fault address for select 2. Select 3 returns zero. Writes to select 2 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select (0 uncorrectable, 1 correctable, 2 fault address, 3 none) |
| reg_wdata | input | 64 | Write data; ones clear status bits |
| reg_rdata | output | 64 | Read data of the selected register |
| ue_evt | input | 1 | Uncorrectable error event strobe |
| ue_is_write | input | 1 | Uncorrectable event was a DMA write (0 = read) |
| ue_xlat | input | 1 | Uncorrectable event was a translation failure |
| ue_mask | input | 16 | Byte mask of the failing uncorrectable access |
| ue_addr | input | ADDR_W | Address of the failing uncorrectable access |
| ue_block | input | 1 | Uncorrectable access was a block transfer |
| ce_evt | input | 1 | Correctable error event strobe |
| ce_is_write | input | 1 | Correctable event was a DMA write (0 = read) |
| ce_mask | input | 16 | Byte mask of the failing correctable access |
| ce_addr | input | ADDR_W | Address of the failing correctable access |
| ce_block | input | 1 | Correctable access was a block transfer |
| ce_synd | input | 8 | ECC syndrome of the correctable event |
| ue_irq | output | 1 | Uncorrectable error interrupt |
| ce_irq | output | 1 | Correctable error interrupt |

## Verification
The assertions assume three things about the inputs. Event fields are valid whenever their strobe is high. An event and a clearing write to the same register in the same cycle follow the clear-first ordering of R8. The capture and hold properties are therefore only checked on cycles with no write to that register, and the write-clear property only on cycles with no event to that register. The stimulus table keeps events and writes on separate cycles. Only the directed tests combine them, and only where a property excludes that combination, for example the same-cycle clear-and-capture case and the simultaneous capture on both ports.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int STAT_W  = 64;
    localparam int MASK_W  = 16;
    localparam int SYND_W  = 8;
    localparam int OFF_W   = 3;
    localparam int SEL_W   = 2;

    // Bit positions that software decodes
    localparam int B_PRIM_RD = 62;
    localparam int B_PRIM_WR = 61;
    localparam int B_SEC_RD  = 59;
    localparam int B_SEC_WR  = 58;
    localparam int B_SEC_XL  = 57;
    localparam int B_PRIM_XL = 56;
    localparam int SYND_LO   = 48;
    localparam int MASK_LO   = 32;
    localparam int OFF_LO    = 29;
    localparam int B_BLOCK   = 23;
    localparam int OFF_ADDR_LO = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_UNCORR = 2'd0,
        SEL_CORR   = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // One error report as seen at an event port
    typedef struct packed {
        logic              is_write;
        logic              xlat;
        logic [MASK_W-1:0] mask;
        logic [OFF_W-1:0]  dw_off;
        logic              block;
        logic [SYND_W-1:0] synd;
    } err_evt_t;

    // Decoded contents of one status register
    typedef struct packed {
        logic              prim_rd;
        logic              prim_wr;
        logic              prim_xl;
        logic              sec_rd;
        logic              sec_wr;
        logic              sec_xl;
        logic [SYND_W-1:0] synd;
        logic [MASK_W-1:0] mask;
        logic [OFF_W-1:0]  dw_off;
        logic              block;
    } err_stat_t;

    function automatic logic [STAT_W-1:0] stat_pack(input err_stat_t s);
        logic [STAT_W-1:0] v;
        v = '0;
        v[B_PRIM_RD] = s.prim_rd;
        v[B_PRIM_WR] = s.prim_wr;
        v[B_PRIM_XL] = s.prim_xl;
        v[B_SEC_RD]  = s.sec_rd;
        v[B_SEC_WR]  = s.sec_wr;
        v[B_SEC_XL]  = s.sec_xl;
        v[SYND_LO +: SYND_W] = s.synd;
        v[MASK_LO +: MASK_W] = s.mask;
        v[OFF_LO  +: OFF_W]  = s.dw_off;
        v[B_BLOCK] = s.block;
        return v;
    endfunction

    function automatic err_stat_t stat_unpack(input logic [STAT_W-1:0] v);
        err_stat_t s;
        s.prim_rd = v[B_PRIM_RD];
        s.prim_wr = v[B_PRIM_WR];
        s.prim_xl = v[B_PRIM_XL];
        s.sec_rd  = v[B_SEC_RD];
        s.sec_wr  = v[B_SEC_WR];
        s.sec_xl  = v[B_SEC_XL];
        s.synd    = v[SYND_LO +: SYND_W];
        s.mask    = v[MASK_LO +: MASK_W];
        s.dw_off  = v[OFF_LO  +: OFF_W];
        s.block   = v[B_BLOCK];
        return s;
    endfunction

    function automatic logic prim_held(input err_stat_t s);
        return s.prim_rd | s.prim_wr | s.prim_xl;
    endfunction

    function automatic logic any_event(input err_stat_t s);
        return s.prim_rd | s.prim_wr | s.prim_xl | s.sec_rd | s.sec_wr | s.sec_xl;
    endfunction

endpackage

// File: rtl/err_status_reg.sv
module err_status_reg
    import dma_err_pkg::*;
#(
    parameter bit HAS_XLAT = 1'b1,
    parameter bit HAS_SYND = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_vld,
    input  err_evt_t          evt,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat_vec,
    output logic              held_after_clr,
    output logic              capture,
    output logic              irq
);

    err_stat_t stat_q;
    err_stat_t cleared;
    err_stat_t stat_d;
    logic      xl_in;
    logic [SYND_W-1:0] synd_in;

    generate
        if (HAS_XLAT) begin : g_xlat
            assign xl_in = evt.xlat;
        end else begin : g_no_xlat
            assign xl_in = 1'b0;
        end
        if (HAS_SYND) begin : g_synd
            assign synd_in = evt.synd;
        end else begin : g_no_synd
            assign synd_in = '0;
        end
    endgenerate

    // Clear first, then apply the event to what is left
    always_comb begin
        cleared = stat_unpack(stat_pack(stat_q) & ~(clr_en ? clr_mask : '0));
        held_after_clr = prim_held(cleared);
        capture = evt_vld && !held_after_clr;
        stat_d = cleared;
        if (capture) begin
            stat_d.prim_rd = !evt.is_write;
            stat_d.prim_wr = evt.is_write;
            stat_d.prim_xl = xl_in;
            stat_d.mask    = evt.mask;
            stat_d.dw_off  = evt.dw_off;
            stat_d.block   = evt.block;
            stat_d.synd    = synd_in;
        end else if (evt_vld) begin
            stat_d.sec_rd = cleared.sec_rd | !evt.is_write;
            stat_d.sec_wr = cleared.sec_wr | evt.is_write;
            stat_d.sec_xl = cleared.sec_xl | xl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_vec = stat_pack(stat_q);
    assign irq      = any_event(stat_q);

endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg #(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ue_load,
    input  logic [ADDR_W-1:0] ue_addr,
    input  logic              ce_load,
    input  logic [ADDR_W-1:0] ce_addr,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ue_load) begin
            addr_q <= ue_addr;
        end else if (ce_load) begin
            addr_q <= ce_addr;
        end
    end

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import dma_err_pkg::*;
#(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              ue_evt,
    input  logic              ue_is_write,
    input  logic              ue_xlat,
    input  logic [15:0]       ue_mask,
    input  logic [ADDR_W-1:0] ue_addr,
    input  logic              ue_block,
    input  logic              ce_evt,
    input  logic              ce_is_write,
    input  logic [15:0]       ce_mask,
    input  logic [ADDR_W-1:0] ce_addr,
    input  logic              ce_block,
    input  logic [7:0]        ce_synd,
    output logic              ue_irq,
    output logic              ce_irq
);

    localparam int OFF_HI = OFF_ADDR_LO + OFF_W - 1;

    err_evt_t          ue_pkt, ce_pkt;
    logic [STAT_W-1:0] ue_stat_vec, ce_stat_vec;
    logic              ue_held, ce_held, ue_cap, ce_cap;
    logic              ue_clr, ce_clr;
    logic [ADDR_W-1:0] fault_addr_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        ue_pkt.is_write = ue_is_write;
        ue_pkt.xlat     = ue_xlat;
        ue_pkt.mask     = ue_mask;
        ue_pkt.dw_off   = ue_addr[OFF_HI:OFF_ADDR_LO];
        ue_pkt.block    = ue_block;
        ue_pkt.synd     = '0;
        ce_pkt.is_write = ce_is_write;
        ce_pkt.xlat     = 1'b0;
        ce_pkt.mask     = ce_mask;
        ce_pkt.dw_off   = ce_addr[OFF_HI:OFF_ADDR_LO];
        ce_pkt.block    = ce_block;
        ce_pkt.synd     = ce_synd;
    end

    assign ue_clr = reg_wr && (sel == SEL_UNCORR);
    assign ce_clr = reg_wr && (sel == SEL_CORR);

    err_status_reg #(.HAS_XLAT(1'b1), .HAS_SYND(1'b0)) u_uncorr (
        .clk            (clk),
        .rst            (rst),
        .evt_vld        (ue_evt),
        .evt            (ue_pkt),
        .clr_en         (ue_clr),
        .clr_mask       (reg_wdata),
        .stat_vec       (ue_stat_vec),
        .held_after_clr (ue_held),
        .capture        (ue_cap),
        .irq            (ue_irq)
    );

    err_status_reg #(.HAS_XLAT(1'b0), .HAS_SYND(1'b1)) u_corr (
        .clk            (clk),
        .rst            (rst),
        .evt_vld        (ce_evt),
        .evt            (ce_pkt),
        .clr_en         (ce_clr),
        .clr_mask       (reg_wdata),
        .stat_vec       (ce_stat_vec),
        .held_after_clr (ce_held),
        .capture        (ce_cap),
        .irq            (ce_irq)
    );

    // Address belongs to the first primary record across both registers
    fault_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ue_load (ue_cap && !ce_held),
        .ue_addr (ue_addr),
        .ce_load (ce_cap && !ue_held && !ue_cap),
        .ce_addr (ce_addr),
        .addr_q  (fault_addr_q)
    );

    always_comb begin
        case (sel)
            SEL_UNCORR: reg_rdata = ue_stat_vec;
            SEL_CORR:   reg_rdata = ce_stat_vec;
            SEL_ADDR:   reg_rdata = 64'(fault_addr_q);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_err_capture_chk.sv
module dma_err_capture_chk #(
    parameter int ADDR_W = 34
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [63:0]       reg_wdata,
    input logic              ue_evt,
    input logic              ue_is_write,
    input logic              ce_evt,
    input logic [7:0]        ce_synd,
    input logic              ue_irq,
    input logic              ce_irq,
    input logic [63:0]       ue_stat,
    input logic [63:0]       ce_stat,
    input logic [ADDR_W-1:0] fault_addr
);

    logic ue_prim, ce_prim;
    assign ue_prim = ue_stat[62] | ue_stat[61] | ue_stat[56];
    assign ce_prim = ce_stat[62] | ce_stat[61] | ce_stat[56];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ue_stat == 64'd0 && ce_stat == 64'd0 && fault_addr == '0));

    p_first_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (ue_evt && !ue_is_write && !ue_prim && !(reg_wr && reg_sel == 2'd0))
        |=> (ue_stat[62] && !ue_stat[61]));

    p_ce_synd_r3: assert property (@(posedge clk) disable iff (rst)
        (ce_evt && !ce_prim && !(reg_wr && reg_sel == 2'd1))
        |=> (ce_stat[55:48] == $past(ce_synd)));

    p_secondary_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (ue_evt && ue_is_write && ue_prim && !reg_wr)
        |=> (ue_stat[58] && $stable(ue_stat[47:0])));

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0 && !ue_evt)
        |=> ((ue_stat & $past(reg_wdata)) == 64'd0));

    p_ue_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ue_irq) |-> $past(ue_evt));

    p_ce_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_irq) |-> ($past(reg_wr) || $past(rst)));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((ue_prim && !(reg_wr && reg_sel == 2'd0)) || (ce_prim && !(reg_wr && reg_sel == 2'd1)))
        |=> $stable(fault_addr));

endmodule

bind dma_err_capture dma_err_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .ue_evt      (ue_evt),
    .ue_is_write (ue_is_write),
    .ce_evt      (ce_evt),
    .ce_synd     (ce_synd),
    .ue_irq      (ue_irq),
    .ce_irq      (ce_irq),
    .ue_stat     (ue_stat_vec),
    .ce_stat     (ce_stat_vec),
    .fault_addr  (fault_addr_q)
);

// File: tb/tb_dma_err_capture.sv
module tb_dma_err_capture;

    localparam int AW = 34;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          ue_evt = 1'b0, ue_is_write = 1'b0, ue_xlat = 1'b0, ue_block = 1'b0;
    logic [15:0]   ue_mask = '0;
    logic [AW-1:0] ue_addr = '0;
    logic          ce_evt = 1'b0, ce_is_write = 1'b0, ce_block = 1'b0;
    logic [15:0]   ce_mask = '0;
    logic [AW-1:0] ce_addr = '0;
    logic [7:0]    ce_synd = '0;
    logic          ue_irq, ce_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dma_err_capture #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ue_evt(ue_evt), .ue_is_write(ue_is_write), .ue_xlat(ue_xlat),
        .ue_mask(ue_mask), .ue_addr(ue_addr), .ue_block(ue_block),
        .ce_evt(ce_evt), .ce_is_write(ce_is_write), .ce_mask(ce_mask),
        .ce_addr(ce_addr), .ce_block(ce_block), .ce_synd(ce_synd),
        .ue_irq(ue_irq), .ce_irq(ce_irq)
    );

    // op: 0 none, 1 uncorrectable event, 2 correctable event, 3 register write
    typedef struct packed {
        logic [1:0]  op;
        logic        wr;
        logic        xl;
        logic [15:0] msk;
        logic [33:0] adr;
        logic        blk;
        logic [7:0]  syn;
        logic [1:0]  wsel;
        logic [63:0] wdat;
        logic [1:0]  csel;
        logic [63:0] exp;
        logic        eui;
        logic        eci;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 1'b0, 1'b0, 16'h00FF, 34'h1_2345_6728, 1'b1, 8'h00, 2'd0, 64'h0, 2'd0, 64'h4000_00FF_A080_0000, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0, 2'd2, 64'h1_2345_6728, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b1, 16'hFFFF, 34'h38, 1'b0, 8'h00, 2'd0, 64'h0, 2'd0, 64'h4600_00FF_A080_0000, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0, 2'd2, 64'h1_2345_6728, 1'b1, 1'b0},
        '{2'd2, 1'b1, 1'b0, 16'hF00F, 34'h10, 1'b0, 8'h5A, 2'd0, 64'h0, 2'd1, 64'h205A_F00F_4000_0000, 1'b1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0, 2'd2, 64'h1_2345_6728, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h4000_0000_0000_0000, 2'd0, 64'h0600_00FF_A080_0000, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0600_00FF_A080_0000, 2'd0, 64'h0, 1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 64'h0, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 64'h1_2345_6728, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 16'h0001, 34'h3_FFFF_FFF8, 1'b1, 8'h01, 2'd0, 64'h0, 2'd1, 64'h4001_0001_E080_0000, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0, 2'd2, 64'h3_FFFF_FFF8, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 34'h0, 1'b0, 8'h00, 2'd0, 64'h0, 2'd3, 64'h0, 1'b0, 1'b1}
    };

    // Requirement exercised by each table row
    string req_of [NV] = '{"R2", "R7", "R4", "R7", "R3", "R7", "R5", "R6",
                           "R5", "R9", "R3", "R7", "R9"};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; ue_evt = 1'b0; ce_evt = 1'b0;
        ue_xlat = 1'b0; ue_is_write = 1'b0; ce_is_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] sel, input logic [63:0] exp);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic run_row(input int i);
        vec_t v;
        v = TBL[i];
        @(negedge clk);
        case (v.op)
            2'd1: begin
                ue_evt = 1'b1; ue_is_write = v.wr; ue_xlat = v.xl;
                ue_mask = v.msk; ue_addr = v.adr; ue_block = v.blk;
            end
            2'd2: begin
                ce_evt = 1'b1; ce_is_write = v.wr; ce_mask = v.msk;
                ce_addr = v.adr; ce_block = v.blk; ce_synd = v.syn;
            end
            2'd3: begin
                reg_wr = 1'b1; reg_sel = v.wsel; reg_wdata = v.wdat;
            end
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
        read_chk(req_of[i], v.csel, v.exp);
        check({req_of[i], "/R6 ue_irq"}, {63'd0, ue_irq}, {63'd0, v.eui});
        check({req_of[i], "/R6 ce_irq"}, {63'd0, ce_irq}, {63'd0, v.eci});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1: reset state
        read_chk("R1", 2'd0, 64'h0);
        read_chk("R1", 2'd1, 64'h0);
        read_chk("R1", 2'd2, 64'h0);
        check("R1 irq", {62'd0, ue_irq, ce_irq}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            run_row(i);
        end

        // R8: clear of the primary and a new correctable event in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 64'h4000_0000_0000_0000;
        ce_evt = 1'b1; ce_is_write = 1'b1; ce_mask = 16'h0003;
        ce_addr = 34'h8; ce_block = 1'b0; ce_synd = 8'h22;
        @(negedge clk);
        idle_inputs();
        read_chk("R8", 2'd1, 64'h2022_0003_2000_0000);
        read_chk("R8", 2'd2, 64'h8);

        // R7: both ports capture in the same cycle
        do_reset();
        @(negedge clk);
        ue_evt = 1'b1; ue_is_write = 1'b0; ue_mask = 16'h0000; ue_addr = 34'h100; ue_block = 1'b0;
        ce_evt = 1'b1; ce_is_write = 1'b0; ce_mask = 16'h0000; ce_addr = 34'h200; ce_block = 1'b0;
        ce_synd = 8'h00;
        @(negedge clk);
        idle_inputs();
        read_chk("R7", 2'd2, 64'h100);
        read_chk("R7", 2'd0, 64'h4000_0000_0000_0000);
        // R3: correctable register never shows translation bits
        read_chk("R3", 2'd1, 64'h4000_0000_0000_0000);

        // R2: translation failure as primary
        do_reset();
        @(negedge clk);
        ue_evt = 1'b1; ue_is_write = 1'b0; ue_xlat = 1'b1; ue_mask = 16'hFFFF;
        ue_addr = 34'h0; ue_block = 1'b0;
        @(negedge clk);
        idle_inputs();
        read_chk("R2", 2'd0, 64'h4100_FFFF_0000_0000);

        // R6 and R5: clear only the event bits, fields stay, interrupt drops
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 64'h4100_0000_0000_0000;
        @(negedge clk);
        idle_inputs();
        read_chk("R5", 2'd0, 64'h0000_FFFF_0000_0000);
        check("R6 fields only", {63'd0, ue_irq}, 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule